// File: doc/BRIEF.md
# UART Receiver Status Flag Register

This block gathers the event strobes of a serial port into one 16-bit status word. The receive shifter, baud logic, smart-card retry engine and LIN sync measurement sit outside it and report only single-cycle strobes. The block turns those strobes into sticky flags that software clears by writing 1. A frame-format input decides which flags may be set at all. The receiver-enable input flushes every flag that belongs to the receive side.

Frame and parity errors are not raised at once. They are tagged onto the received character and stored with it in a small receive queue. The visible error bits therefore always describe the character that the next data read will return, and they advance when the data register is read. A one-entry hold stage stands for the shift register: it keeps a completed character that found the queue full. A start bit that arrives while both the queue and the hold stage are full raises the overflow flag.

Top module: `uart_stat_reg`

## Requirements
- R1: After reset `stat_rd` is 0x0000 (with `cts_pin` low), and bits 15:8 of `stat_rd` are always zero.
- R2: For the sticky bits 7, 6, 5, 4, 2, 1 and 0, a bus write of 1 to a bit clears it and a write of 0 leaves it unchanged. Bit 3 and bits 15:8 ignore writes.
- R3: When a set event and a write-1 clear hit the same sticky bit in the same cycle, the bit ends up set.
- R4: Bit 3 of `stat_rd` follows `cts_pin` combinationally, with no register in the path.
- R5: Bit 1 (frame error) is set for a received character whose first stop bit is sampled low (`rx_stop_bit` = 0).
- R6: Bit 0 (parity error) can be set only when `fmt` is 0x1, 0x5 or 0x7. In any other format, a parity mismatch is dropped.
- R7: Bit 4 (inconsistent sync) is set on a sync strobe only when `fmt` is 0x4 or 0x5 and `sync_byte` differs from 0x55.
- R8: Bit 2 (overflow) is set when a start bit arrives while the two-entry queue is full and a further character waits in the hold stage. A start bit with a full queue and an empty hold stage does not set it.
- R9: Bits 1:0 show the error tags of the queue head. A data read (`data_rd`) advances them to the next character, and a write-1 clears only the head's tags.
- R10: Bit 5 (collision) is set by a collision strobe only while `coll_det_en` is high.
- R11: Bit 6 (transmitter empty) is set when transmission completes with `tx_empty` high and `fmt` is 0x2 (LIN host). In any other format it reads 0, and leaving 0x2 clears it.
- R12: Bit 7 (retry limit) is set by the retry-limit strobe and is unaffected by receiver enable or format.
- R13: While `rx_en` is low, bits 5, 4, 2, 1 and 0 are cleared, the queue is emptied, and receive-side strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low flushes receive flags and queue |
| fmt | input | 4 | Frame-format selector |
| coll_det_en | input | 1 | Collision detection enable |
| cts_pin | input | 1 | Live CTS pin level |
| wr_en | input | 1 | Bus write strobe to the status word |
| wr_data | input | 16 | Bus write data; 1 bits clear sticky flags |
| data_rd | input | 1 | Data register read; pops the queue head |
| ev_rx_char | input | 1 | Character completed by the receive shifter |
| rx_stop_bit | input | 1 | Sampled level of the first stop bit of that character |
| rx_par_bad | input | 1 | Parity mismatch for that character |
| ev_rx_start | input | 1 | New start bit detected |
| ev_sync | input | 1 | Sync byte captured in auto-baud formats |
| sync_byte | input | 8 | The captured sync byte |
| ev_tx_done | input | 1 | Ongoing transmission finished |
| tx_empty | input | 1 | Transmit data holder is empty |
| ev_coll | input | 1 | Collision observed on the line |
| ev_retry_max | input | 1 | Retry limit reached |
| stat_rd | output | 16 | Status word |

## Verification
The hardest state to reach from the ports is the overflow condition. It needs a full queue, a character parked in the hold stage and a fresh start bit, all with no intervening data read. The bench pushes three characters back to back and probes with a start bit both before and after the third push, so it sees the flag stay low with only the queue full and rise once the hold stage is occupied. Per-character staging is driven by queuing a clean character ahead of a faulty one. The bench then shows that the error bits stay low until a data read brings the faulty character to the head.

// File: rtl/ustat_pkg.sv
`timescale 1ns/1ps
package ustat_pkg;

    localparam int STAT_W = 16;
    localparam int FMT_W  = 4;

    // Positions inside the status word
    localparam int B_ITER = 7;
    localparam int B_TXE  = 6;
    localparam int B_COLL = 5;
    localparam int B_ISF  = 4;
    localparam int B_CTS  = 3;
    localparam int B_OVF  = 2;
    localparam int B_FERR = 1;
    localparam int B_PERR = 0;

    // Positions inside the sticky flag bank
    localparam int NSTK   = 5;
    localparam int S_ITER = 4;
    localparam int S_TXE  = 3;
    localparam int S_COLL = 2;
    localparam int S_ISF  = 1;
    localparam int S_OVF  = 0;

    typedef logic [FMT_W-1:0] fmt_t;

    // Error tags carried with every received character
    typedef struct packed {
        logic ferr;
        logic perr;
    } rx_err_t;

    function automatic logic fmt_has_parity(input fmt_t f);
        return (f == 4'h1) || (f == 4'h5) || (f == 4'h7);
    endfunction

    function automatic logic fmt_is_autobaud(input fmt_t f);
        return (f == 4'h4) || (f == 4'h5);
    endfunction

endpackage

// File: rtl/ustat_w1c.sv
`timescale 1ns/1ps
module ustat_w1c #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] wclr,
    input  logic [W-1:0] kill,
    output logic [W-1:0] q
);
    // kill beats set, set beats a software clear
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (kill[i])
                q[i] <= 1'b0;
            else if (set[i])
                q[i] <= 1'b1;
            else if (wclr[i])
                q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/ustat_rxq.sv
`timescale 1ns/1ps
module ustat_rxq import ustat_pkg::*; #(
    parameter int DEPTH = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    flush,
    input  logic    push,
    input  rx_err_t push_err,
    input  logic    pop,
    input  rx_err_t clr_err,
    input  logic    start_ev,
    output rx_err_t head_err,
    output logic    ovf_ev
);
    localparam int CW = $clog2(DEPTH + 1);

    rx_err_t        ent_q [DEPTH];
    rx_err_t        ent_n [DEPTH];
    logic [CW-1:0]  cnt_q, cnt_n;
    rx_err_t        hold_q, hold_n;
    logic           hv_q, hv_n;
    logic           pop_ok;

    assign pop_ok = pop && (cnt_q != '0);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) ent_n[i] = ent_q[i];
        cnt_n  = cnt_q;
        hold_n = hold_q;
        hv_n   = hv_q;

        // software clear touches the head only while it stays the head
        if ((cnt_q != '0) && !pop_ok)
            ent_n[0] = rx_err_t'(ent_q[0] & ~clr_err);

        if (pop_ok) begin
            for (int i = 0; i < DEPTH - 1; i++) ent_n[i] = ent_q[i + 1];
            ent_n[DEPTH-1] = '0;
            cnt_n = cnt_q - CW'(1);
            if (hv_q) begin
                for (int i = 0; i < DEPTH; i++)
                    if (CW'(i) == cnt_n) ent_n[i] = hold_q;
                cnt_n = cnt_n + CW'(1);
                hv_n  = 1'b0;
            end
        end

        if (push) begin
            if (cnt_n < CW'(DEPTH)) begin
                for (int i = 0; i < DEPTH; i++)
                    if (CW'(i) == cnt_n) ent_n[i] = push_err;
                cnt_n = cnt_n + CW'(1);
            end else if (!hv_n) begin
                hold_n = push_err;
                hv_n   = 1'b1;
            end
        end

        if (flush) begin
            for (int i = 0; i < DEPTH; i++) ent_n[i] = '0;
            cnt_n  = '0;
            hold_n = '0;
            hv_n   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
            cnt_q  <= '0;
            hold_q <= '0;
            hv_q   <= 1'b0;
        end else begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_n[i];
            cnt_q  <= cnt_n;
            hold_q <= hold_n;
            hv_q   <= hv_n;
        end
    end

    assign head_err = (cnt_q != '0) ? ent_q[0] : '0;
    assign ovf_ev   = start_ev && (cnt_q == CW'(DEPTH)) && hv_q;

endmodule

// File: rtl/uart_stat_reg.sv
`timescale 1ns/1ps
module uart_stat_reg import ustat_pkg::*; #(
    parameter int   RXQ_DEPTH    = 2,
    parameter fmt_t LIN_HOST_FMT = 4'h2,
    parameter logic [7:0] SYNC_WORD = 8'h55
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic [FMT_W-1:0]  fmt,
    input  logic              coll_det_en,
    input  logic              cts_pin,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              data_rd,
    input  logic              ev_rx_char,
    input  logic              rx_stop_bit,
    input  logic              rx_par_bad,
    input  logic              ev_rx_start,
    input  logic              ev_sync,
    input  logic [7:0]        sync_byte,
    input  logic              ev_tx_done,
    input  logic              tx_empty,
    input  logic              ev_coll,
    input  logic              ev_retry_max,
    output logic [STAT_W-1:0] stat_rd
);
    logic            is_lin;
    logic [NSTK-1:0] stk_set, stk_clr, stk_kill, stk_q;
    rx_err_t         new_err, clr_err, head_err;
    logic            ovf_ev;
    logic            unused_wr;

    assign is_lin    = (fmt == LIN_HOST_FMT);
    assign unused_wr = ^{wr_data[STAT_W-1:8], wr_data[B_CTS]};

    // error tags of an incoming character
    assign new_err.ferr = ~rx_stop_bit;
    assign new_err.perr = rx_par_bad & fmt_has_parity(fmt);

    assign clr_err.ferr = wr_en & wr_data[B_FERR];
    assign clr_err.perr = wr_en & wr_data[B_PERR];

    ustat_rxq #(.DEPTH(RXQ_DEPTH)) u_rxq (
        .clk      (clk),
        .rst      (rst),
        .flush    (~rx_en),
        .push     (ev_rx_char & rx_en),
        .push_err (new_err),
        .pop      (data_rd),
        .clr_err  (clr_err),
        .start_ev (ev_rx_start & rx_en),
        .head_err (head_err),
        .ovf_ev   (ovf_ev)
    );

    always_comb begin
        stk_set          = '0;
        stk_set[S_ITER]  = ev_retry_max;
        stk_set[S_TXE]   = ev_tx_done & tx_empty & is_lin;
        stk_set[S_COLL]  = ev_coll & coll_det_en & rx_en;
        stk_set[S_ISF]   = ev_sync & rx_en & fmt_is_autobaud(fmt) & (sync_byte != SYNC_WORD);
        stk_set[S_OVF]   = ovf_ev;

        stk_clr          = '0;
        stk_clr[S_ITER]  = wr_en & wr_data[B_ITER];
        stk_clr[S_TXE]   = wr_en & wr_data[B_TXE];
        stk_clr[S_COLL]  = wr_en & wr_data[B_COLL];
        stk_clr[S_ISF]   = wr_en & wr_data[B_ISF];
        stk_clr[S_OVF]   = wr_en & wr_data[B_OVF];

        stk_kill         = '0;
        stk_kill[S_TXE]  = ~is_lin;
        stk_kill[S_COLL] = ~rx_en;
        stk_kill[S_ISF]  = ~rx_en;
        stk_kill[S_OVF]  = ~rx_en;
    end

    ustat_w1c #(.W(NSTK)) u_flags (
        .clk  (clk),
        .rst  (rst),
        .set  (stk_set),
        .wclr (stk_clr),
        .kill (stk_kill),
        .q    (stk_q)
    );

    always_comb begin
        stat_rd         = '0;
        stat_rd[B_ITER] = stk_q[S_ITER];
        stat_rd[B_TXE]  = stk_q[S_TXE] & is_lin;
        stat_rd[B_COLL] = stk_q[S_COLL];
        stat_rd[B_ISF]  = stk_q[S_ISF];
        stat_rd[B_CTS]  = cts_pin;
        stat_rd[B_OVF]  = stk_q[S_OVF];
        stat_rd[B_FERR] = head_err.ferr;
        stat_rd[B_PERR] = head_err.perr;
    end

endmodule

// File: rtl/ustat_chk.sv
`timescale 1ns/1ps
module ustat_chk import ustat_pkg::*; #(
    parameter fmt_t LIN_HOST_FMT = 4'h2,
    parameter logic [7:0] SYNC_WORD = 8'h55
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_en,
    input logic [FMT_W-1:0]  fmt,
    input logic              coll_det_en,
    input logic              cts_pin,
    input logic              ev_coll,
    input logic              ev_sync,
    input logic [7:0]        sync_byte,
    input logic              ev_retry_max,
    input logic [STAT_W-1:0] stat_rd
);
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
        stat_rd[STAT_W-1:8] == '0);

    a_r4_cts_live: assert property (@(posedge clk) disable iff (rst)
        stat_rd[B_CTS] == cts_pin);

    a_r11_txe_masked: assert property (@(posedge clk) disable iff (rst)
        (fmt != LIN_HOST_FMT) |-> !stat_rd[B_TXE]);

    a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
        ev_retry_max |=> stat_rd[B_ITER]);

    a_r13_rx_flush: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (stat_rd[B_COLL] == 1'b0) && (stat_rd[B_ISF] == 1'b0) &&
                   (stat_rd[B_OVF] == 1'b0) && (stat_rd[B_FERR] == 1'b0) &&
                   (stat_rd[B_PERR] == 1'b0));

    a_r10_coll_gated: assert property (@(posedge clk) disable iff (rst)
        (!stat_rd[B_COLL] && !(ev_coll && coll_det_en)) |=> !stat_rd[B_COLL]);

    a_r7_sync_gated: assert property (@(posedge clk) disable iff (rst)
        (!stat_rd[B_ISF] && !(ev_sync && fmt_is_autobaud(fmt) && (sync_byte != SYNC_WORD)))
            |=> !stat_rd[B_ISF]);
endmodule

bind uart_stat_reg ustat_chk #(
    .LIN_HOST_FMT (LIN_HOST_FMT),
    .SYNC_WORD    (SYNC_WORD)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_en        (rx_en),
    .fmt          (fmt),
    .coll_det_en  (coll_det_en),
    .cts_pin      (cts_pin),
    .ev_coll      (ev_coll),
    .ev_sync      (ev_sync),
    .sync_byte    (sync_byte),
    .ev_retry_max (ev_retry_max),
    .stat_rd      (stat_rd)
);

// File: tb/tb_uart_stat_reg.sv
`timescale 1ns/1ps
module tb_uart_stat_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_en = 1'b0;
    logic [3:0]  fmt = 4'h0;
    logic        coll_det_en = 1'b0;
    logic        cts_pin = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        data_rd = 1'b0;
    logic        ev_rx_char = 1'b0;
    logic        rx_stop_bit = 1'b1;
    logic        rx_par_bad = 1'b0;
    logic        ev_rx_start = 1'b0;
    logic        ev_sync = 1'b0;
    logic [7:0]  sync_byte = 8'h55;
    logic        ev_tx_done = 1'b0;
    logic        tx_empty = 1'b0;
    logic        ev_coll = 1'b0;
    logic        ev_retry_max = 1'b0;
    logic [15:0] stat_rd;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    uart_stat_reg dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .fmt(fmt), .coll_det_en(coll_det_en),
        .cts_pin(cts_pin), .wr_en(wr_en), .wr_data(wr_data), .data_rd(data_rd),
        .ev_rx_char(ev_rx_char), .rx_stop_bit(rx_stop_bit), .rx_par_bad(rx_par_bad),
        .ev_rx_start(ev_rx_start), .ev_sync(ev_sync), .sync_byte(sync_byte),
        .ev_tx_done(ev_tx_done), .tx_empty(tx_empty), .ev_coll(ev_coll),
        .ev_retry_max(ev_retry_max), .stat_rd(stat_rd)
    );

    typedef struct packed {
        logic [3:0] f;
        logic       stop;
        logic       par;
        logic [7:0] sync;
        logic [7:0] exp;
    } vec_t;

    // R5 R6 R7: one character plus one sync strobe per format
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 1'b1, 1'b1, 8'h12, 8'h00},
        '{4'h0, 1'b0, 1'b0, 8'h55, 8'h02},
        '{4'h1, 1'b1, 1'b1, 8'h12, 8'h01},
        '{4'h4, 1'b1, 1'b1, 8'h12, 8'h10},
        '{4'h5, 1'b0, 1'b1, 8'h12, 8'h13},
        '{4'h5, 1'b1, 1'b0, 8'h55, 8'h00},
        '{4'h7, 1'b1, 1'b1, 8'hAA, 8'h01},
        '{4'h4, 1'b0, 1'b0, 8'h55, 8'h02},
        '{4'h2, 1'b1, 1'b1, 8'h00, 8'h00}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_stat(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic push_char(input logic stop, input logic par);
        ev_rx_char = 1'b1; rx_stop_bit = stop; rx_par_bad = par;
        step();
        ev_rx_char = 1'b0; rx_stop_bit = 1'b1; rx_par_bad = 1'b0;
    endtask

    task automatic pulse_start();
        ev_rx_start = 1'b1;
        step();
        ev_rx_start = 1'b0;
    endtask

    task automatic pulse_read();
        data_rd = 1'b1;
        step();
        data_rd = 1'b0;
    endtask

    task automatic rx_flush();
        rx_en = 1'b0;
        step();
        rx_en = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) step();
        chk("R1 during reset", stat_rd, 16'h0000);
        rst = 1'b0;
        step();
        chk("R1 after reset", stat_rd, 16'h0000);

        // table walk
        for (int i = 0; i < NV; i++) begin
            rx_en = 1'b0;
            step();
            rx_en = 1'b1; fmt = VECS[i].f;
            ev_rx_char = 1'b1; rx_stop_bit = VECS[i].stop; rx_par_bad = VECS[i].par;
            ev_sync = 1'b1; sync_byte = VECS[i].sync;
            step();
            ev_rx_char = 1'b0; rx_stop_bit = 1'b1; rx_par_bad = 1'b0;
            ev_sync = 1'b0; sync_byte = 8'h55;
            chk($sformatf("R5/R6/R7 vector %0d", i), stat_rd, {8'h00, VECS[i].exp});
        end
        rx_flush();
        fmt = 4'h0;

        // R4 CTS follows pin
        cts_pin = 1'b1;
        #2;
        chk("R4 cts high", stat_rd, 16'h0008);
        step();
        // R2 CTS and upper bits ignore writes
        write_stat(16'hFFFF);
        chk("R2 cts/upper write ignored", stat_rd, 16'h0008);
        cts_pin = 1'b0;
        #2;
        chk("R4 cts low", stat_rd, 16'h0000);
        step();

        // R12, R2, R3
        ev_retry_max = 1'b1; step(); ev_retry_max = 1'b0;
        chk("R12 retry flag set", stat_rd, 16'h0080);
        write_stat(16'h0000);
        chk("R2 write zero keeps", stat_rd, 16'h0080);
        write_stat(16'h0080);
        chk("R2 write one clears", stat_rd, 16'h0000);
        ev_retry_max = 1'b1; write_stat(16'h0080); ev_retry_max = 1'b0;
        chk("R3 set wins over clear", stat_rd, 16'h0080);
        write_stat(16'h0080);

        // R10 collision gating
        coll_det_en = 1'b0;
        ev_coll = 1'b1; step(); ev_coll = 1'b0;
        chk("R10 coll blocked", stat_rd, 16'h0000);
        coll_det_en = 1'b1;
        ev_coll = 1'b1; step(); ev_coll = 1'b0;
        chk("R10 coll set", stat_rd, 16'h0020);

        // R13 receiver disable
        fmt = 4'h4;
        ev_sync = 1'b1; sync_byte = 8'h00; step(); ev_sync = 1'b0; sync_byte = 8'h55;
        push_char(1'b0, 1'b0);
        chk("R13 flags before disable", stat_rd, 16'h0032);
        rx_en = 1'b0;
        step();
        chk("R13 disable clears", stat_rd, 16'h0000);
        ev_coll = 1'b1; ev_sync = 1'b1; sync_byte = 8'h00;
        push_char(1'b0, 1'b0);
        ev_coll = 1'b0; ev_sync = 1'b0; sync_byte = 8'h55;
        rx_en = 1'b1;
        step();
        chk("R13 events ignored when disabled", stat_rd, 16'h0000);
        coll_det_en = 1'b0;

        // R8 overflow
        fmt = 4'h0;
        push_char(1'b1, 1'b0);
        push_char(1'b1, 1'b0);
        pulse_start();
        chk("R8 full queue no hold", stat_rd, 16'h0000);
        push_char(1'b1, 1'b0);
        pulse_start();
        chk("R8 overflow set", stat_rd, 16'h0004);
        write_stat(16'h0004);
        chk("R8 overflow cleared", stat_rd, 16'h0000);
        rx_flush();

        // R9 staging
        fmt = 4'h1;
        push_char(1'b1, 1'b0);
        push_char(1'b0, 1'b1);
        chk("R9 head clean", stat_rd, 16'h0000);
        pulse_read();
        chk("R9 advance to bad char", stat_rd, 16'h0003);
        write_stat(16'h0002);
        chk("R9 clear head ferr", stat_rd, 16'h0001);
        pulse_read();
        chk("R9 queue empty", stat_rd, 16'h0000);
        rx_flush();

        // R11 transmitter empty
        fmt = 4'h2;
        tx_empty = 1'b0;
        ev_tx_done = 1'b1; step(); ev_tx_done = 1'b0;
        chk("R11 holder not empty", stat_rd, 16'h0000);
        tx_empty = 1'b1;
        ev_tx_done = 1'b1; step(); ev_tx_done = 1'b0;
        chk("R11 txe set", stat_rd, 16'h0040);
        fmt = 4'h0;
        step();
        chk("R11 masked out of LIN host", stat_rd, 16'h0000);
        fmt = 4'h2;
        #2;
        chk("R11 cleared on mode leave", stat_rd, 16'h0000);
        step();

        summary();
        $finish;
    end
endmodule